// File: doc/BRIEF.md
# Clock Divider Factor Calculator

This block works out the settings for an output clock that can only divide its source. It takes a parent frequency and a wanted frequency, both 32-bit integers in hertz. It returns a two-bit power-of-two prescale exponent and a five-bit linear divide field. The linear divide field holds the linear ratio minus one. The block also returns the frequency that those settings actually produce, which software can use to decide whether the result is close enough.

The prescale exponent it picks is the smallest one that brings the remaining ratio below 32. The linear ratio is then rounded up, so the output never runs faster than asked. The achieved frequency is recomputed from the chosen factors.

A single restoring divider, 32 cycles per quotient, is shared between two passes. The first pass forms the integer ratio. The second pass forms the achieved frequency. In round-only mode the block reports just the achieved frequency. The factor outputs then keep the values of the last program-mode run.

Top module: `clkfac_calc`

## Requirements
- R1: When `req_hz` is greater than `parent_hz`, the calculation uses `parent_hz` as the wanted frequency.
- R2: With the ratio defined as `parent_hz / req_hz` truncated, `p_field` is 0 if the ratio is below 32. Otherwise it is 1 if ratio/2 is below 32, otherwise 2 if ratio/4 is below 32, and otherwise 3.
- R3: The linear ratio is the ratio divided by 2^P, rounded up. `m_field` (bits 4:0) holds the linear ratio minus one.
- R4: `achieved_hz` equals (`parent_hz` >> P) divided by the linear ratio, truncated.
- R5: A wanted frequency of zero, whether given directly or produced by the clamp of R1, yields `p_field`=3 and `m_field`=31. The achieved frequency is then (`parent_hz`>>3)/32.
- R6: When P=3 and the rounded linear ratio exceeds 32, it saturates at 32 (`m_field`=31). The achieved frequency is computed from 32. The linear ratio is never below 1.
- R7: When `round_only`=1 at start, only `achieved_hz` is updated. `m_field` and `p_field` keep their previous values.
- R8: A start pulse taken while idle raises `busy` in the next cycle. `done` is a one-cycle pulse with `busy` low and all results valid, and it comes within 100 cycles of start.
- R9: A `start` asserted while `busy` is high is ignored. The running result is unchanged and no further `done` follows.
- R10: After reset, `busy`, `done`, `achieved_hz`, `m_field` and `p_field` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calculation; inputs are sampled in the same cycle |
| round_only | input | 1 | 1: update only the achieved frequency |
| parent_hz | input | 32 | Parent clock frequency |
| req_hz | input | 32 | Wanted output frequency |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse, results valid |
| achieved_hz | output | 32 | Frequency produced by the chosen factors |
| m_field | output | 5 | Linear ratio minus one |
| p_field | output | 2 | Prescale exponent |

## Verification
The table of vectors places the ratio on each side of each prescale step:
- Ratios 31 and 32 separate P=0 from P=1.
- Ratio 64 separates P=1 from P=2.
- Ratios 127 and 257 separate P=2 from P=3, and 257 also hits saturation.

Inexact ratios such as 33 and 34 show whether the linear ratio is rounded up rather than truncated. Large ratios on a 24 MHz parent and an all-ones parent show the saturation at 32 and the recomputed achieved frequency.

A wanted frequency above the parent, a wanted frequency of zero, and a zero parent exercise the clamp and the zero path. Directed runs then cover the following:
- A round-only call that follows a program call, to confirm the fields hold.
- A start issued in the middle of a run, to confirm it is ignored.

// File: rtl/clkfac_pkg.sv
package clkfac_pkg;

    localparam int FREQ_W  = 32;
    localparam int PEXP_W  = 2;
    localparam int MFLD_W  = 5;
    localparam int LIN_MAX = 1 << MFLD_W;
    localparam int LIN_W   = MFLD_W + 1;
    localparam int PEXP_MAX = (1 << PEXP_W) - 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RATIO = 2'd1,
        ST_FREQ  = 2'd2
    } calc_state_e;

    typedef struct packed {
        logic [PEXP_W-1:0] pexp;
        logic [LIN_W-1:0]  lin;
    } factor_t;

    function automatic logic [FREQ_W-1:0] clamp_req(input logic [FREQ_W-1:0] parent,
                                                     input logic [FREQ_W-1:0] req);
        return (req > parent) ? parent : req;
    endfunction

endpackage

// File: rtl/clkfac_divider.sv
module clkfac_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         valid,
    output logic [W-1:0] quotient
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] cnt;
    logic          run;
    logic [W-1:0]  rem_q, quo_q, dvs_q, dvd_q;
    logic [W:0]    trial;
    logic [W-1:0]  rem_nx, quo_nx;

    always_comb begin
        trial = {rem_q, quo_q[W-1]};
        if (trial >= {1'b0, dvs_q}) begin
            rem_nx = W'(trial - {1'b0, dvs_q});
            quo_nx = {quo_q[W-2:0], 1'b1};
        end else begin
            rem_nx = trial[W-1:0];
            quo_nx = {quo_q[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            run   <= 1'b0;
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            dvd_q <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (go) begin
                quo_q <= dividend;
                dvd_q <= dividend;
                dvs_q <= divisor;
                rem_q <= '0;
                cnt   <= CW'(W);
                run   <= 1'b1;
            end else if (run) begin
                rem_q <= rem_nx;
                quo_q <= quo_nx;
                cnt   <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run   <= 1'b0;
                    valid <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q;

    // The quotient is the truncated one: q*d <= n < (q+1)*d (feeds R4 and R2)
    assert_quot_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (valid && dvs_q != '0) |->
            ((2*W)'(quo_q) * (2*W)'(dvs_q) <= (2*W)'(dvd_q)) &&
            (((2*W)'(quo_q) + 1) * (2*W)'(dvs_q) > (2*W)'(dvd_q)))
        else $error("divider quotient out of bounds");

endmodule

// File: rtl/clkfac_prescale.sv
module clkfac_prescale
    import clkfac_pkg::*;
#(
    parameter int W = FREQ_W
) (
    input  logic [W-1:0] ratio,
    output factor_t      fac
);
    logic [W:0]        rounded;
    logic [W:0]        bias;
    logic [PEXP_W-1:0] pexp;

    always_comb begin
        pexp = PEXP_W'(PEXP_MAX);
        for (int i = PEXP_MAX - 1; i >= 0; i--) begin
            if ((ratio >> i) < W'(LIN_MAX))
                pexp = PEXP_W'(i);
        end
        bias    = ((W+1)'(1) << pexp) - (W+1)'(1);
        rounded = ({1'b0, ratio} + bias) >> pexp;
        fac.pexp = pexp;
        if (rounded > (W+1)'(LIN_MAX))
            fac.lin = LIN_W'(LIN_MAX);
        else if (rounded == '0)
            fac.lin = LIN_W'(1);
        else
            fac.lin = LIN_W'(rounded);
    end

    always_comb begin
        assert_lin_range_R6: assert (fac.lin >= LIN_W'(1) && fac.lin <= LIN_W'(LIN_MAX))
            else $error("linear ratio outside 1..%0d", LIN_MAX);
    end

endmodule

// File: rtl/clkfac_calc.sv
module clkfac_calc
    import clkfac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              round_only,
    input  logic [FREQ_W-1:0] parent_hz,
    input  logic [FREQ_W-1:0] req_hz,
    output logic              busy,
    output logic              done,
    output logic [FREQ_W-1:0] achieved_hz,
    output logic [MFLD_W-1:0] m_field,
    output logic [PEXP_W-1:0] p_field
);
    calc_state_e       st;
    logic [FREQ_W-1:0] parent_q;
    logic              round_q;
    factor_t           fac_q;
    factor_t           fac_sel;
    logic              div_go;
    logic [FREQ_W-1:0] div_a, div_b;
    logic              div_valid;
    logic [FREQ_W-1:0] div_q;
    logic [FREQ_W-1:0] req_eff;

    assign req_eff = clamp_req(parent_hz, req_hz);

    clkfac_divider #(.W(FREQ_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .go       (div_go),
        .dividend (div_a),
        .divisor  (div_b),
        .valid    (div_valid),
        .quotient (div_q)
    );

    clkfac_prescale #(.W(FREQ_W)) u_pre (
        .ratio (div_q),
        .fac   (fac_sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            parent_q    <= '0;
            round_q     <= 1'b0;
            fac_q       <= '0;
            div_go      <= 1'b0;
            div_a       <= '0;
            div_b       <= '0;
            busy        <= 1'b0;
            done        <= 1'b0;
            achieved_hz <= '0;
            m_field     <= '0;
            p_field     <= '0;
        end else begin
            done   <= 1'b0;
            div_go <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        parent_q <= parent_hz;
                        round_q  <= round_only;
                        busy     <= 1'b1;
                        div_go   <= 1'b1;
                        if (req_eff == '0) begin
                            fac_q.pexp <= PEXP_W'(PEXP_MAX);
                            fac_q.lin  <= LIN_W'(LIN_MAX);
                            div_a      <= parent_hz >> PEXP_MAX;
                            div_b      <= FREQ_W'(LIN_MAX);
                            st         <= ST_FREQ;
                        end else begin
                            div_a <= parent_hz;
                            div_b <= req_eff;
                            st    <= ST_RATIO;
                        end
                    end
                end
                ST_RATIO: begin
                    if (div_valid) begin
                        fac_q  <= fac_sel;
                        div_a  <= parent_q >> fac_sel.pexp;
                        div_b  <= FREQ_W'(fac_sel.lin);
                        div_go <= 1'b1;
                        st     <= ST_FREQ;
                    end
                end
                ST_FREQ: begin
                    if (div_valid) begin
                        achieved_hz <= div_q;
                        if (!round_q) begin
                            m_field <= MFLD_W'(fac_q.lin - LIN_W'(1));
                            p_field <= fac_q.pexp;
                        end
                        done <= 1'b1;
                        busy <= 1'b0;
                        st   <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than one cycle");

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy) else $error("done while busy");

    assert_start_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && start) |=> busy) else $error("busy not raised");

    assert_round_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (done && round_q) |-> ($stable(m_field) && $stable(p_field)))
        else $error("fields changed in round-only mode");

    assert_clamp_R1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && start && req_hz > parent_hz && parent_hz != '0)
            |=> (div_b == $past(parent_hz)))
        else $error("wanted frequency not clamped");

endmodule

// File: tb/clkfac_calc_tb.sv
`timescale 1ns/1ps
module clkfac_calc_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        round_only = 1'b0;
    logic [31:0] parent_hz = '0;
    logic [31:0] req_hz = '0;
    logic        busy, done;
    logic [31:0] achieved_hz;
    logic [4:0]  m_field;
    logic [1:0]  p_field;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    clkfac_calc u_dut (
        .clk(clk), .rst(rst), .start(start), .round_only(round_only),
        .parent_hz(parent_hz), .req_hz(req_hz), .busy(busy), .done(done),
        .achieved_hz(achieved_hz), .m_field(m_field), .p_field(p_field)
    );

    typedef struct packed {
        logic [31:0] pa;
        logic [31:0] rq;
        logic [1:0]  p;
        logic [4:0]  m;
        logic [31:0] ach;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{32'd24000000, 32'd1000000, 2'd0, 5'd23, 32'd1000000},
        '{32'd24000000, 32'd100000,  2'd3, 5'd29, 32'd100000},
        '{32'd24000000, 32'd700000,  2'd1, 5'd16, 32'd705882},
        '{32'd1000,     32'd5000,    2'd0, 5'd0,  32'd1000},
        '{32'd24000000, 32'd0,       2'd3, 5'd31, 32'd93750},
        '{32'd24000000, 32'd10000,   2'd3, 5'd31, 32'd93750},
        '{32'd100,      32'd3,       2'd1, 5'd16, 32'd2},
        '{32'd31,       32'd1,       2'd0, 5'd30, 32'd1},
        '{32'd32,       32'd1,       2'd1, 5'd15, 32'd1},
        '{32'd64,       32'd1,       2'd2, 5'd15, 32'd1},
        '{32'd127,      32'd1,       2'd2, 5'd31, 32'd0},
        '{32'd257,      32'd1,       2'd3, 5'd31, 32'd1},
        '{32'hFFFFFFFF, 32'd1,       2'd3, 5'd31, 32'd16777215},
        '{32'd0,        32'd5,       2'd3, 5'd31, 32'd0}
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic launch(input logic [31:0] pa, input logic [31:0] rq, input logic rnd);
        @(negedge clk);
        parent_hz  = pa;
        req_hz     = rq;
        round_only = rnd;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8 busy after start", busy, 1);
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (done) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
        check(seen, "R8 done within 100 cycles", seen, 1);
        if (seen) check(busy == 1'b0, "R8 busy low at done", busy, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(busy == 0 && done == 0, "R10 handshake idle", {busy, done}, 0);
        check(achieved_hz == 0, "R10 achieved zero", achieved_hz, 0);
        check(m_field == 0 && p_field == 0, "R10 fields zero", {p_field, m_field}, 0);

        // R1..R6 vector table, program mode
        for (int v = 0; v < NV; v++) begin
            launch(VEC[v].pa, VEC[v].rq, 1'b0);
            wait_done(seen);
            if (seen) begin
                check(p_field == VEC[v].p, "R2 R5 prescale", p_field, VEC[v].p);
                check(m_field == VEC[v].m, "R3 R6 linear field", m_field, VEC[v].m);
                check(achieved_hz == VEC[v].ach, "R4 R1 achieved", achieved_hz, VEC[v].ach);
                @(negedge clk);
                check(done == 1'b0, "R8 done one cycle", done, 0);
            end
        end

        // R7 round-only keeps fields from the previous program run
        launch(32'd24000000, 32'd1000000, 1'b0);
        wait_done(seen);
        launch(32'd24000000, 32'd100000, 1'b1);
        wait_done(seen);
        check(achieved_hz == 32'd100000, "R7 achieved updated", achieved_hz, 100000);
        check(m_field == 5'd23, "R7 m_field held", m_field, 23);
        check(p_field == 2'd0, "R7 p_field held", p_field, 0);

        // R9 start during busy is ignored
        launch(32'd24000000, 32'd700000, 1'b0);
        repeat (5) @(negedge clk);
        parent_hz = 32'd1000;
        req_hz    = 32'd5000;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        check(achieved_hz == 32'd705882, "R9 result unchanged", achieved_hz, 705882);
        check(m_field == 5'd16 && p_field == 2'd1, "R9 fields unchanged",
              {p_field, m_field}, {2'd1, 5'd16});
        @(negedge clk);
        seen = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (done) seen = 1'b1;
            @(negedge clk);
        end
        check(!seen, "R9 no second done", seen, 0);
        check(busy == 1'b0, "R9 stays idle", busy, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule